// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five localities (numbered 0 to 4) owns a shared register window at any moment. Each locality sees a byte-wide access register in its own 4 KiB slice of the address space. A host write to that register either asks for ownership on behalf of the locality or hands ownership back. A host read shows whether the locality is the current owner, whether its own request is still waiting, and, for the owner, whether any other locality is waiting behind it.

The block holds one owner at most, plus a set of waiting requests. When the window is free, a request is granted at the very clock edge that captures it. When the owner lets go and several localities are waiting, the highest-numbered one takes over at the same edge. Each change of owner produces a one-cycle event pulse. The interrupt logic uses this pulse as its locality-change status bit (bit 2 of its status word).

Reads are combinational from the address. Writes take effect at the rising clock edge on which the write strobe is sampled.

Top module: `loc_arbiter`

## Requirements
- R1: The access register of locality l (l in 0..4) is at address {l[2:0], 12'h000}. Reads of any other offset, or with a locality field of 5 to 7, return 8'h00, and writes there change nothing.
- R2: Bit 7 of every access register reads 1.
- R3: Bit 5 of an access register reads 1 only for the locality that currently owns the window, and at most one locality owns it.
- R4: A write with bit 1 set to a locality that is not the owner records a waiting request, which reads back as bit 1 of that locality's register. The same write from the owner has no effect.
- R5: With no owner, a request is granted at the edge that samples the write. In the next cycle that register reads bit 5 = 1 and bit 1 = 0.
- R6: A write with bit 5 set to the owner's register releases ownership. At the same edge the highest-numbered waiting locality is granted; if none is waiting, the window stays free.
- R7: Bit 2 reads 1 in the owner's register exactly when some other locality has a waiting request, and reads 0 in every non-owner register.
- R8: A write with bit 5 set to a non-owner's register only clears that locality's own waiting request. If bits 1 and 5 are both set in such a write, the request ends up cleared.
- R9: `locChange` is high for exactly the one cycle after each edge at which ownership changes, including a change to or from no owner. It stays low otherwise.
- R10: After reset there is no owner and no waiting request, and `locChange` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, sampled at the rising edge |
| addr | input | 15 | Host byte address: locality in bits 14:12, offset in bits 11:0 |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Combinational read data for `addr` |
| locChange | output | 1 | One-cycle locality-change event pulse |

## Verification
The hardest case to reach from the ports is a release while an arbitrary set of other localities is waiting. At that moment the priority pick, the clearing of the winner's request, the pending-flag update and the event pulse all resolve at a single edge. The bench drives the window into that state for every owner and every one of the 32 waiting-set masks. For each combination it first grants the owner, then queues the masked requests (the owner's own request is included and must be ignored), and then releases. It works out the winner arithmetically as the highest set bit of the mask with the owner removed.

// File: rtl/locarb_pkg.sv
package locarb_pkg;
  localparam int LOC_W = 3;
  localparam int BIT_VALID = 7;
  localparam int BIT_ACTIVE = 5;
  localparam int BIT_WAITING = 2;
  localparam int BIT_REQUEST = 1;

  typedef struct packed {
    logic             hit;
    logic [LOC_W-1:0] loc;
    logic             req;
    logic             rel;
  } strobe_t;
endpackage

// File: rtl/loc_ctrl.sv
module loc_ctrl
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int OFS_W   = 12,
  localparam int ADDR_W = LOC_W + OFS_W
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output strobe_t           stb,
  output logic              rdHit,
  output logic [LOC_W-1:0]  rdLoc
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

  logic [LOC_W-1:0] locField;
  logic             regHit;
  logic             unusedBits;

  assign locField   = addr[ADDR_W-1:OFS_W];
  assign regHit     = (locField <= LAST_LOC) && (addr[OFS_W-1:0] == '0);
  assign unusedBits = ^{wrData[7:6], wrData[4:2], wrData[0]};

  always_comb begin
    stb.hit = wrEn && regHit;
    stb.loc = locField;
    stb.req = wrData[BIT_REQUEST];
    stb.rel = wrData[BIT_ACTIVE];
  end

  assign rdHit = regHit;
  assign rdLoc = locField;
endmodule

// File: rtl/loc_dp.sv
module loc_dp
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               rdHit,
  input  logic [LOC_W-1:0]   rdLoc,
  output logic [7:0]         rdData,
  output logic               ownerValid,
  output logic [LOC_W-1:0]   owner,
  output logic [NUM_LOC-1:0] pending,
  output logic               locChange
);
  logic                isOwnerWr;
  logic                relNow;
  logic [NUM_LOC-1:0]  pendMerged;
  logic [NUM_LOC-1:0]  pendNext;
  logic                nextValid;
  logic [LOC_W-1:0]    nextOwner;
  logic [LOC_W-1:0]    winner;
  logic                changeNow;

  assign isOwnerWr = stb.hit && ownerValid && (owner == stb.loc);
  assign relNow    = isOwnerWr && stb.rel;

  always_comb begin
    pendMerged = pending;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (stb.hit && !isOwnerWr && (stb.loc == LOC_W'(i))) begin
        if (stb.req) pendMerged[i] = 1'b1;
        if (stb.rel) pendMerged[i] = 1'b0;
      end
    end
  end

  always_comb begin
    winner = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (pendMerged[i]) winner = LOC_W'(i);
    end
  end

  always_comb begin
    pendNext = pendMerged;
    if (ownerValid && !relNow) begin
      nextValid = 1'b1;
      nextOwner = owner;
    end else if (pendMerged != '0) begin
      nextValid = 1'b1;
      nextOwner = winner;
      for (int i = 0; i < NUM_LOC; i++) begin
        if (winner == LOC_W'(i)) pendNext[i] = 1'b0;
      end
    end else begin
      nextValid = 1'b0;
      nextOwner = '0;
    end
  end

  assign changeNow = (nextValid != ownerValid) ||
                     (nextValid && (nextOwner != owner));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerValid <= 1'b0;
      owner      <= '0;
      pending    <= '0;
      locChange  <= 1'b0;
    end else begin
      ownerValid <= nextValid;
      owner      <= nextOwner;
      pending    <= pendNext;
      locChange  <= changeNow;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (rdHit) begin
      rdData[BIT_VALID] = 1'b1;
      if (ownerValid && (owner == rdLoc)) begin
        rdData[BIT_ACTIVE]  = 1'b1;
        rdData[BIT_WAITING] = (pending != '0);
      end
      for (int i = 0; i < NUM_LOC; i++) begin
        if (rdLoc == LOC_W'(i)) rdData[BIT_REQUEST] = pending[i];
      end
    end
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int OFS_W   = 12,
  localparam int ADDR_W = LOC_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              locChange
);
  strobe_t            stb;
  logic               rdHit;
  logic [LOC_W-1:0]   rdLoc;
  logic               ownerValid;
  logic [LOC_W-1:0]   owner;
  logic [NUM_LOC-1:0] pending;

  loc_ctrl #(.NUM_LOC(NUM_LOC), .OFS_W(OFS_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .stb(stb), .rdHit(rdHit), .rdLoc(rdLoc)
  );

  loc_dp #(.NUM_LOC(NUM_LOC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdHit(rdHit), .rdLoc(rdLoc),
    .rdData(rdData), .ownerValid(ownerValid), .owner(owner),
    .pending(pending), .locChange(locChange)
  );
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               ownerValid,
  input logic [LOC_W-1:0]   owner,
  input logic [NUM_LOC-1:0] pending,
  input logic               locChange
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

  // R3: an owner is always a real locality
  a_r3_owner_range: assert property (@(posedge clk) disable iff (!rstN)
    ownerValid |-> (owner <= LAST_LOC));

  // R3 / R5: the owner never also sits in the waiting set
  a_r5_owner_not_waiting: assert property (@(posedge clk) disable iff (!rstN)
    ownerValid |-> (((pending >> owner) & NUM_LOC'(1)) == '0));

  // R5: a free window never keeps a waiting request past an edge
  a_r5_idle_no_wait: assert property (@(posedge clk) disable iff (!rstN)
    !ownerValid |-> (pending == '0));

  // R9: a pulse only follows a real change of ownership
  a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    locChange |-> (($past(ownerValid) != ownerValid) || ($past(owner) != owner)));

  // R9: every change of ownership is flagged
  a_r9_change_flagged: assert property (@(posedge clk) disable iff (!rstN)
    ((ownerValid != $past(ownerValid)) ||
     (ownerValid && $past(ownerValid) && (owner != $past(owner)))) |-> locChange);
endmodule

bind loc_arbiter loc_arbiter_chk #(.NUM_LOC(NUM_LOC)) u_chk (
  .clk(clk), .rstN(rstN), .ownerValid(ownerValid), .owner(owner),
  .pending(pending), .locChange(locChange)
);

// File: tb/loc_arbiter_bench.sv
module loc_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        locChange;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  loc_arbiter u_loc_arbiter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .locChange(locChange)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(int loc, logic [11:0] ofs, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    addr = {loc[2:0], ofs};
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(int loc, logic [11:0] ofs, output logic [7:0] v);
    addr = {loc[2:0], ofs};
    #1;
    v = rdData;
  endtask

  function automatic logic [7:0] expReg(bit own, bit othersWait, bit selfWait);
    return 8'h80 | (own ? 8'h20 : 8'h00) | (othersWait ? 8'h04 : 8'h00) |
           (selfWait ? 8'h02 : 8'h00);
  endfunction

  function automatic int highest(int m);
    int h = -1;
    for (int i = 0; i < 5; i++) if (m[i]) h = i;
    return h;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    doReset();
    // R10 and R2: reset state
    for (int l = 0; l < 5; l++) begin
      readReg(l, 12'h000, v);
      check("R10/R2 reset reg", v, 8'h80);
    end
    check("R10 locChange after reset", {7'b0, locChange}, 8'h00);

    // R1: decode holes
    readReg(5, 12'h000, v);
    check("R1 locality 5 read", v, 8'h00);
    readReg(7, 12'h000, v);
    check("R1 locality 7 read", v, 8'h00);
    readReg(2, 12'h004, v);
    check("R1 other offset read", v, 8'h00);
    doWrite(5, 12'h000, 8'h02);
    check("R1 write loc5 no event", {7'b0, locChange}, 8'h00);
    doWrite(1, 12'h018, 8'h02);
    check("R1 write offset no event", {7'b0, locChange}, 8'h00);
    for (int l = 0; l < 5; l++) begin
      readReg(l, 12'h000, v);
      check("R1 ignored write leaves regs", v, 8'h80);
    end

    // R8: non-owner release clears own request; owner unchanged
    doWrite(0, 12'h000, 8'h02);
    check("R5 grant pulse", {7'b0, locChange}, 8'h01);
    doWrite(3, 12'h000, 8'h02);
    readReg(0, 12'h000, v);
    check("R7 owner sees waiter", v, expReg(1, 1, 0));
    readReg(3, 12'h000, v);
    check("R4 request visible", v, expReg(0, 0, 1));
    doWrite(3, 12'h000, 8'h20);
    check("R8 no event on non-owner release", {7'b0, locChange}, 8'h00);
    readReg(3, 12'h000, v);
    check("R8 request cleared", v, expReg(0, 0, 0));
    readReg(0, 12'h000, v);
    check("R8 owner kept, no waiter", v, expReg(1, 0, 0));
    doWrite(4, 12'h000, 8'h22);
    readReg(4, 12'h000, v);
    check("R8 both bits leaves clear", v, expReg(0, 0, 0));
    doWrite(0, 12'h000, 8'h20);
    check("R6 release to free pulse", {7'b0, locChange}, 8'h01);
    readReg(0, 12'h000, v);
    check("R6 released reg", v, expReg(0, 0, 0));

    // Sweep: every owner against every waiting set (R3..R7, R9)
    for (int a = 0; a < 5; a++) begin
      for (int m = 0; m < 32; m++) begin
        int others;
        int w;
        others = m & ~(1 << a);
        doReset();
        doWrite(a, 12'h000, 8'h02);
        check("R9 grant pulse", {7'b0, locChange}, 8'h01);
        readReg(a, 12'h000, v);
        check("R5 granted reg", v, expReg(1, 0, 0));
        @(negedge clk);
        check("R9 pulse one cycle", {7'b0, locChange}, 8'h00);
        for (int l = 0; l < 5; l++) begin
          if (m[l]) doWrite(l, 12'h000, 8'h02);
        end
        check("R4 no event while queueing", {7'b0, locChange}, 8'h00);
        for (int l = 0; l < 5; l++) begin
          readReg(l, 12'h000, v);
          if (l == a) check("R7 owner waiting flag", v, expReg(1, others != 0, 0));
          else check("R3/R4 non-owner reg", v, expReg(0, 0, others[l]));
        end
        doWrite(a, 12'h000, 8'h20);
        check("R9 release pulse", {7'b0, locChange}, 8'h01);
        w = highest(others);
        for (int l = 0; l < 5; l++) begin
          readReg(l, 12'h000, v);
          if (l == w)
            check("R6 winner reg", v, expReg(1, (others & ~(1 << w)) != 0, 0));
          else
            check("R6 loser reg", v, expReg(0, 0, (l != a) && (w >= 0) && others[l]));
        end
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule